// File: doc/BRIEF.md
# Dual-Port RAM Collision Arbiter

This block is a true dual-port memory of 9-bit words with two independent ports, left and right. Each port has its own chip enable, write select, output enable, address, write data and read data. Reads from both ports may target the same word in the same cycle. When both ports are enabled on one address, the block resolves the clash. The port whose access on that address was already present wins. The other port is flagged busy, and any write it attempts is dropped.

A mode input selects how the busy decision is made. In master mode the block runs its own arbitration and drives a registered busy flag to each port. In slave mode it ignores its own result and takes a busy input per port from a master elsewhere. This lets several devices sit side by side to widen the data word while one device decides for all of them. The model is synchronous with a single clock. The depth is 2**ADDR_W words, and ADDR_W of 13 or 14 gives 8K or 16K words.

Top module: `dpram_guard`

## Requirements
- R1: While reset is high and on the first cycle after it, both busy outputs and both read data outputs are 0.
- R2: A port with ce=1 and we=1 stores its write data at its address, unless that write is inhibited. A port with ce=1 and we=0 reads. The read data appears on the port's rdata after the next clock edge and is the word held before any write made in the same cycle. If oe was 0 during that read, rdata is 0. Between reads, rdata holds its value.
- R3: Both ports may read the same address in one cycle, and both receive the stored word.
- R4: In master mode, a collision exists when both ce are 1 and the addresses are equal. When a collision begins, a port whose ce was 1 on the same address in the previous cycle is "held". If exactly one port is held, that port wins. The loser's busy output is 1 after the next clock edge, and the winner's stays 0.
- R5: When a collision begins and neither port is held, the left port wins.
- R6: Once chosen, the winner stays the same for every cycle the collision persists.
- R7: Busy outputs return to 0 on the edge after a cycle in which the addresses differ or either ce is 0.
- R8: In master mode, a write by the losing port during a collision leaves the array unchanged.
- R9: The winning port reads and writes normally during a collision. A read by the losing port returns the array contents.
- R10: In slave mode, both busy outputs are 0. A port's write is inhibited exactly when its busy input is 1. If both ports write one address with neither inhibited, the right port's data is stored.
- R11: A port with ce=0 never causes a collision, and no busy is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_sel | input | 1 | 1 = master (local arbitration), 0 = slave (busy inputs) |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write select (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable for reads |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_in | input | 1 | Left busy from master (slave mode) |
| l_busy_out | output | 1 | Left busy flag (master mode) |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write select (1 = write, 0 = read) |
| r_oe | input | 1 | Right output enable for reads |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_in | input | 1 | Right busy from master (slave mode) |
| r_busy_out | output | 1 | Right busy flag (master mode) |

## Verification
The bench targets several corner cases. One is a collision whose two accesses begin in the same cycle: a design without the left tie-break would flag the wrong port or both ports. Another is a collision in which both ports later look "held": a design that re-arbitrates every cycle would move busy between the ports. A losing port's write to the shared word must leave the word unchanged. A design that gated the write with the registered busy flag would let the first colliding write through and corrupt it. Slave-mode traffic with random busy inputs confirms that the local arbitration neither shows on the outputs nor blocks writes.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } win_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L    = 0;
  localparam int unsigned PORT_R    = 1;
endpackage

// File: rtl/dpg_port_track.sv
module dpg_port_track #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [ADDR_W-1:0] addr,
  output logic              held
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= ce;
      addr_q <= addr;
    end
  end

  // the access on this address was already running one cycle ago
  assign held = ce_q && (addr_q == addr);
endmodule

// File: rtl/dpg_arbiter.sv
module dpg_arbiter
  import dpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_sel,
  input  logic              ce_l,
  input  logic              ce_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              held_l,
  input  logic              held_r,
  input  logic              busy_in_l,
  input  logic              busy_in_r,
  output logic              blk_l,
  output logic              blk_r,
  output logic              busy_l,
  output logic              busy_r
);
  logic coll, coll_q;
  win_e win_now, win_q;
  logic lose_l, lose_r;

  assign coll = ce_l && ce_r && (addr_l == addr_r);

  always_comb begin
    if (coll_q) begin
      win_now = win_q;
    end else if (held_r && !held_l) begin
      win_now = WIN_RIGHT;
    end else begin
      win_now = WIN_LEFT;
    end
  end

  assign lose_l = coll && (win_now == WIN_RIGHT);
  assign lose_r = coll && (win_now == WIN_LEFT);

  // inhibit acts in the colliding cycle itself, not on the registered flag
  assign blk_l = ms_sel ? lose_l : busy_in_l;
  assign blk_r = ms_sel ? lose_r : busy_in_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      coll_q <= 1'b0;
      win_q  <= WIN_LEFT;
      busy_l <= 1'b0;
      busy_r <= 1'b0;
    end else begin
      coll_q <= coll;
      win_q  <= coll ? win_now : WIN_LEFT;
      busy_l <= ms_sel && lose_l;
      busy_r <= ms_sel && lose_r;
    end
  end
endmodule

// File: rtl/dpg_array.sv
module dpg_array
  import dpg_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned ADDR_W = 11
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PORTS-1:0]             wr_en,
  input  logic [NUM_PORTS-1:0]             rd_en,
  input  logic [NUM_PORTS-1:0]             oe,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // higher port index is applied last and wins an unblocked tie
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (wr_en[p]) begin
        mem[addr[p]] <= wdata[p];
      end
    end
  end

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_rd
    logic [DATA_W-1:0] q;
    logic              oe_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q    <= '0;
        oe_q <= 1'b0;
      end else if (rd_en[gp]) begin
        q    <= mem[addr[gp]];
        oe_q <= oe[gp];
      end
    end

    assign rdata[gp] = oe_q ? q : '0;
  end
endmodule

// File: rtl/dpram_guard.sv
module dpram_guard
  import dpg_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_sel,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_in,
  output logic              l_busy_out,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_in,
  output logic              r_busy_out
);
  logic [NUM_PORTS-1:0]             ce_v, we_v, oe_v, held_v, blk_v;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_v, rdata_v;
  logic [NUM_PORTS-1:0]             wr_en, rd_en;

  assign ce_v    = {r_ce, l_ce};
  assign we_v    = {r_we, l_we};
  assign oe_v    = {r_oe, l_oe};
  assign addr_v  = {r_addr, l_addr};
  assign wdata_v = {r_wdata, l_wdata};

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    dpg_port_track #(.ADDR_W(ADDR_W)) i_track (
      .clk  (clk),
      .rst  (rst),
      .ce   (ce_v[gp]),
      .addr (addr_v[gp]),
      .held (held_v[gp])
    );
    assign wr_en[gp] = ce_v[gp] && we_v[gp] && !blk_v[gp];
    assign rd_en[gp] = ce_v[gp] && !we_v[gp];
  end

  dpg_arbiter #(.ADDR_W(ADDR_W)) i_arb (
    .clk       (clk),
    .rst       (rst),
    .ms_sel    (ms_sel),
    .ce_l      (l_ce),
    .ce_r      (r_ce),
    .addr_l    (l_addr),
    .addr_r    (r_addr),
    .held_l    (held_v[PORT_L]),
    .held_r    (held_v[PORT_R]),
    .busy_in_l (l_busy_in),
    .busy_in_r (r_busy_in),
    .blk_l     (blk_v[PORT_L]),
    .blk_r     (blk_v[PORT_R]),
    .busy_l    (l_busy_out),
    .busy_r    (r_busy_out)
  );

  dpg_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_array (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .oe    (oe_v),
    .addr  (addr_v),
    .wdata (wdata_v),
    .rdata (rdata_v)
  );

  assign l_rdata = rdata_v[PORT_L];
  assign r_rdata = rdata_v[PORT_R];
endmodule

// File: rtl/dpg_checker.sv
module dpg_checker #(
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              ms_sel,
  input logic              l_ce,
  input logic              r_ce,
  input logic [ADDR_W-1:0] l_addr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_out,
  input logic              r_busy_out
);
  logic match;
  assign match = l_ce && r_ce && (l_addr == r_addr);

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (rst)
    !(l_busy_out && r_busy_out)); // R4

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (l_busy_out || r_busy_out) |-> $past(match)); // R11

  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !match |=> !(l_busy_out || r_busy_out)); // R7

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ms_sel |=> !(l_busy_out || r_busy_out)); // R10

  AST_HOLD_RIGHT_WIN: assert property (@(posedge clk) disable iff (rst)
    (l_busy_out && match && ms_sel) |=> l_busy_out); // R6

  AST_HOLD_LEFT_WIN: assert property (@(posedge clk) disable iff (rst)
    (r_busy_out && match && ms_sel) |=> r_busy_out); // R6
endmodule

bind dpram_guard dpg_checker #(.ADDR_W(ADDR_W)) i_dpg_checker (
  .clk        (clk),
  .rst        (rst),
  .ms_sel     (ms_sel),
  .l_ce       (l_ce),
  .r_ce       (r_ce),
  .l_addr     (l_addr),
  .r_addr     (r_addr),
  .l_busy_out (l_busy_out),
  .r_busy_out (r_busy_out)
);

// File: tb/test_dpram_guard.sv
module test_dpram_guard;
  localparam int unsigned DATA_W     = 9;
  localparam int unsigned ADDR_W     = 11;
  localparam int unsigned DEPTH      = 1 << ADDR_W;
  localparam time         CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_sel = 1'b1;
  logic l_ce = 0, l_we = 0, l_oe = 0, l_busy_in = 0;
  logic r_ce = 0, r_we = 0, r_oe = 0, r_busy_in = 0;
  logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
  logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0;
  logic [DATA_W-1:0] l_rdata, r_rdata;
  logic l_busy_out, r_busy_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_guard #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dpram_guard (
    .clk(clk), .rst(rst), .ms_sel(ms_sel),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
  );

  int unsigned vectors = 0;
  int unsigned miscompares = 0;

  // reference model state
  logic [DATA_W-1:0] m_mem [DEPTH];
  logic              p_ce_l = 0, p_ce_r = 0, m_coll_q = 0, m_win_r_q = 0;
  logic [ADDR_W-1:0] p_addr_l = '0, p_addr_r = '0;
  logic [DATA_W-1:0] m_q_l = '0, m_q_r = '0;
  logic              m_oe_l = 0, m_oe_r = 0;
  logic              e_busy_l = 0, e_busy_r = 0;

  function automatic logic [DATA_W-1:0] pattern(input int unsigned a);
    return DATA_W'((a * 37 + 11) % (1 << DATA_W));
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic coll, lheld, rheld, win_r, lose_l, lose_r, blk_l, blk_r;
    logic [DATA_W-1:0] old_l, old_r;
    coll   = l_ce && r_ce && (l_addr == r_addr);
    lheld  = p_ce_l && (p_addr_l == l_addr);
    rheld  = p_ce_r && (p_addr_r == r_addr);
    win_r  = m_coll_q ? m_win_r_q : (rheld && !lheld);
    lose_l = coll && win_r;
    lose_r = coll && !win_r;
    blk_l  = ms_sel ? lose_l : l_busy_in;
    blk_r  = ms_sel ? lose_r : r_busy_in;
    old_l  = m_mem[l_addr];
    old_r  = m_mem[r_addr];
    if (l_ce && !l_we) begin m_q_l = old_l; m_oe_l = l_oe; end
    if (r_ce && !r_we) begin m_q_r = old_r; m_oe_r = r_oe; end
    if (l_ce && l_we && !blk_l) m_mem[l_addr] = l_wdata;
    if (r_ce && r_we && !blk_r) m_mem[r_addr] = r_wdata;
    e_busy_l  = ms_sel && lose_l;
    e_busy_r  = ms_sel && lose_r;
    m_coll_q  = coll;
    m_win_r_q = coll ? win_r : 1'b0;
    p_ce_l = l_ce; p_addr_l = l_addr;
    p_ce_r = r_ce; p_addr_r = r_addr;
    @(posedge clk);
    #1;
    chk(tag, "l_busy_out", DATA_W'(l_busy_out), DATA_W'(e_busy_l));
    chk(tag, "r_busy_out", DATA_W'(r_busy_out), DATA_W'(e_busy_r));
    chk(tag, "l_rdata", l_rdata, m_oe_l ? m_q_l : '0);
    chk(tag, "r_rdata", r_rdata, m_oe_r ? m_q_r : '0);
  endtask

  task automatic drv_l(input logic ce, input logic we, input logic oe,
                       input int unsigned a, input logic [DATA_W-1:0] d);
    l_ce = ce; l_we = we; l_oe = oe; l_addr = ADDR_W'(a); l_wdata = d;
  endtask

  task automatic drv_r(input logic ce, input logic we, input logic oe,
                       input int unsigned a, input logic [DATA_W-1:0] d);
    r_ce = ce; r_we = we; r_oe = oe; r_addr = ADDR_W'(a); r_wdata = d;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs zero while reset is held
    chk("R1", "l_busy_out", DATA_W'(l_busy_out), '0);
    chk("R1", "r_busy_out", DATA_W'(r_busy_out), '0);
    chk("R1", "l_rdata", l_rdata, '0);
    chk("R1", "r_rdata", r_rdata, '0);
    rst = 1'b0;
    step("R1");

    // fill the array so every read has a known word (R2)
    for (int a = 0; a < DEPTH; a++) begin
      drv_l(1, 1, 0, a, pattern(a));
      step("R2 fill");
    end
    drv_l(0, 0, 0, 0, '0);

    // R2: write, read with oe, read without oe
    drv_l(1, 1, 0, 5, 9'h155); step("R2");
    drv_l(1, 0, 1, 5, '0);     step("R2");
    drv_l(1, 0, 0, 5, '0);     step("R2");
    drv_l(0, 0, 0, 0, '0);     step("R2");

    // R3: both ports read one word in the same cycle
    drv_l(1, 0, 1, 5, '0); drv_r(1, 0, 1, 5, '0); step("R3");
    drv_l(0, 0, 0, 0, '0); drv_r(0, 0, 0, 0, '0); step("R3");

    // R4 and R8: left held on 7, right arrives with a write and loses
    drv_l(1, 0, 1, 7, '0);     step("R4");
    drv_r(1, 1, 0, 7, 9'h0F0); step("R4 R8");
    step("R4 R8");
    drv_l(0, 0, 0, 0, '0); drv_r(1, 0, 1, 7, '0); step("R8");

    // R5: both arrive on 9 at once, left wins
    drv_l(0, 0, 0, 0, '0); drv_r(0, 0, 0, 0, '0); step("R5");
    drv_l(1, 1, 0, 9, 9'h1AA); drv_r(1, 1, 0, 9, 9'h033); step("R5");
    drv_l(1, 0, 1, 9, '0); drv_r(0, 0, 0, 0, '0); step("R5");

    // R6 and R7: right held on 12, left joins and loses for several cycles
    drv_l(0, 0, 0, 0, '0); drv_r(1, 0, 1, 12, '0); step("R6");
    drv_l(1, 1, 0, 12, 9'h0C3); step("R6");
    step("R6"); step("R6");
    drv_r(0, 0, 0, 0, '0); step("R7");
    drv_l(1, 0, 1, 12, '0); step("R7");
    drv_l(1, 0, 1, 13, '0); drv_r(1, 0, 1, 13, '0); step("R7");
    drv_r(1, 0, 1, 14, '0); step("R7");

    // R9: winner writes the word the loser is reading
    drv_l(1, 0, 1, 20, '0); drv_r(0, 0, 0, 0, '0); step("R9");
    drv_l(1, 1, 0, 20, 9'h07E); drv_r(1, 0, 1, 20, '0); step("R9");
    drv_l(1, 0, 1, 20, '0); step("R9");
    drv_l(0, 0, 0, 0, '0); drv_r(0, 0, 0, 0, '0); step("R9");

    // R10: slave mode, busy inputs rule the writes
    ms_sel = 1'b0;
    drv_l(1, 1, 0, 30, 9'h111); drv_r(1, 1, 0, 30, 9'h122); step("R10");
    l_busy_in = 1'b1;
    drv_l(1, 1, 0, 31, 9'h144); drv_r(1, 0, 1, 30, '0); step("R10");
    l_busy_in = 1'b0;
    drv_l(1, 0, 1, 31, '0); step("R10");
    ms_sel = 1'b1;

    // R11: disabled left on the same address as right
    drv_l(0, 1, 0, 40, 9'h0AA); drv_r(1, 0, 1, 40, '0); step("R11");
    step("R11");

    // random traffic on a narrow window to force collisions
    for (int n = 0; n < 4000; n++) begin
      ms_sel    = ($urandom % 8) != 0;
      l_busy_in = $urandom % 2;
      r_busy_in = $urandom % 2;
      drv_l(($urandom % 4) != 0, $urandom % 2, $urandom % 2,
            $urandom % 4, DATA_W'($urandom));
      drv_r(($urandom % 4) != 0, $urandom % 2, $urandom % 2,
            $urandom % 4, DATA_W'($urandom));
      step("R2 R4 R6 R8 R10 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule